// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Collector

This block collects up to sixteen separate interrupt requests from an external device and gives a host one gated interrupt line. Each request line is synchronized to the local clock. A request is latched into a pending bit when its line goes from low to high. The host reads the pending vector and clears bits with a write-one-to-clear strobe.

A control register holds two bits. The first is a source select bit. In one setting, all sixteen data lines of the first port are the request sources. In the other setting, the low twelve data lines of that port and the four user-reply inputs of the four ports are the sources. The second bit is an interrupt enable, and its position is fixed. A group indication shows that at least one request is pending, whether or not interrupts are enabled.

Top module: `edge_irq_collector`

## Requirements
- R1: After reset, the pending vector, the control readback, the group indication and the interrupt output are all zero.
- R2: With select bit 0 of the control register clear, a low-to-high transition on data line i (i = 0..15) sets pending bit i. The bit is visible after the third rising clock edge that samples the new level.
- R3: With select bit 0 set, data lines 11:0 map to pending bits 11:0 and reply inputs 3:0 map to pending bits 15:12. Data lines 15:12 are then ignored. With select bit 0 clear, the reply inputs are ignored.
- R4: Only a rising transition sets a bit. A falling transition sets nothing, and a line held high does not set its bit again after that bit is cleared.
- R5: A pending bit stays set until the host writes a one to that bit position with the clear strobe. Clear-mask bits that are zero leave their pending bits unchanged.
- R6: A rising transition that reaches the pending register in the same cycle as a clear of that bit leaves the bit set. A clear applied one cycle later removes it.
- R7: The interrupt output is high exactly when enable bit 9 of the control register is set and at least one pending bit is set. Pending bits keep collecting while the enable bit is clear.
- R8: The group indication is high whenever any pending bit is set, regardless of the enable bit.
- R9: Changing the select bit does not set any pending bit, even when the newly mapped line is already high.
- R10: A control write stores only bit 9 (enable) and bit 0 (select). All other readback bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| data_a | input | 16 | First-port data lines used as request sources |
| reply_in | input | 4 | User-reply inputs of the four ports |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data; bit 9 is enable, bit 0 is select |
| clr_we | input | 1 | Pending clear strobe |
| clr_mask | input | 16 | Write-one-to-clear mask for the pending bits |
| ctl_q | output | 16 | Control register readback |
| pending | output | 16 | Latched request vector |
| group | output | 1 | At least one request is pending |
| irq | output | 1 | Gated interrupt to the host |

## Verification
The hardest case to reach from the ports is a clear that lands in exactly the cycle in which a new rising edge reaches the pending register. Behind the input is a two-stage synchronizer and an edge register. The stimulus raises a line on a falling clock edge and then counts two full clock periods. It then asserts the clear strobe so that both events are sampled at the same rising edge. A second run applies the clear one period later, which confirms that the timing of the first run is exact. Mode switches are checked with the newly mapped line already held high, so that a spurious edge would show at once in the pending vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  parameter int NUM_REQ     = 16;
  parameter int DATA_W      = 16;
  parameter int NUM_REPLY   = 4;
  parameter int CTL_W       = 16;
  parameter int EN_BIT      = 9;
  parameter int SEL_BIT     = 0;
  parameter int SYNC_STAGES = 2;

  localparam int DATA_LOW = NUM_REQ - NUM_REPLY;
  localparam int RAW_W    = DATA_W + NUM_REPLY;
  localparam logic [CTL_W-1:0] CTL_KEEP =
    (CTL_W'(1) << EN_BIT) | (CTL_W'(1) << SEL_BIT);

  typedef enum logic {
    MAP_ALL_DATA = 1'b0,
    MAP_SPLIT    = 1'b1
  } map_mode_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 20,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_nxt;

  always_comb begin
    stg_nxt[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_nxt[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_nxt;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_nxt;

  always_comb prev_nxt = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_nxt;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_nxt;
  logic [N-1:0] kill;

  always_comb begin
    kill     = clr_we ? clr_mask : '0;
    pend_nxt = (pend_q & ~kill) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign pend = pend_q;
endmodule

// File: rtl/edge_irq_collector.sv
module edge_irq_collector
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    data_a,
  input  logic [NUM_REPLY-1:0] reply_in,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic                 clr_we,
  input  logic [NUM_REQ-1:0]   clr_mask,
  output logic [CTL_W-1:0]     ctl_q,
  output logic [NUM_REQ-1:0]   pending,
  output logic                 group,
  output logic                 irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CTL_W-1:0] ctl_reg_q;
  logic [CTL_W-1:0] ctl_reg_nxt;

  always_comb begin
    ctl_reg_nxt = ctl_reg_q;
    if (ctl_we) ctl_reg_nxt = ctl_wdata & CTL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctl_reg_q <= '0;
    else            ctl_reg_q <= ctl_reg_nxt;
  end

  map_mode_e mode;
  assign mode = map_mode_e'(ctl_reg_q[SEL_BIT]);

  logic [RAW_W-1:0] raw_lvl;
  logic [RAW_W-1:0] sync_lvl;
  logic [RAW_W-1:0] raw_rise;

  assign raw_lvl = {reply_in, data_a};

  irqc_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (raw_lvl),
    .q     (sync_lvl)
  );

  irqc_edge #(.W(RAW_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lvl   (sync_lvl),
    .rise  (raw_rise)
  );

  logic [DATA_W-1:0]    rise_data;
  logic [NUM_REPLY-1:0] rise_reply;
  logic [NUM_REQ-1:0]   rise_map;

  assign rise_data  = raw_rise[DATA_W-1:0];
  assign rise_reply = raw_rise[RAW_W-1:DATA_W];

  always_comb begin
    unique case (mode)
      MAP_SPLIT:    rise_map = {rise_reply, rise_data[DATA_LOW-1:0]};
      default:      rise_map = rise_data[NUM_REQ-1:0];
    endcase
  end

  irqc_pend #(.N(NUM_REQ)) u_pend (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_vec  (rise_map),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .pend     (pending)
  );

  assign ctl_q = ctl_reg_q;
  assign group = |pending;
  assign irq   = group & ctl_reg_q[EN_BIT];
endmodule

// File: rtl/edge_irq_collector_chk.sv
module edge_irq_collector_chk
  import irqc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clr_we,
  input logic [NUM_REQ-1:0] clr_mask,
  input logic [CTL_W-1:0]   ctl_q,
  input logic [NUM_REQ-1:0] pending,
  input logic [NUM_REQ-1:0] rise_map,
  input logic               group,
  input logic               irq
);
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[EN_BIT] |-> !irq); // R7

  AST_IRQ_IMPLIES_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> group); // R8

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pending & $past(pending)) == $past(pending))); // R5

  AST_SET_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pending & ~$past(pending) & ~$past(rise_map)) == '0)); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pending & $past(clr_mask) & ~$past(rise_map)) == '0)); // R5

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pending & $past(rise_map)) == $past(rise_map))); // R6

  AST_CTL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~CTL_KEEP) == '0); // R10
endmodule

bind edge_irq_collector edge_irq_collector_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_we   (clr_we),
  .clr_mask (clr_mask),
  .ctl_q    (ctl_q),
  .pending  (pending),
  .rise_map (rise_map),
  .group    (group),
  .irq      (irq)
);

// File: tb/edge_irq_collector_test.sv
`timescale 1ns/1ps
module edge_irq_collector_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] data_a;
  logic [3:0]  reply_in;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic        clr_we;
  logic [15:0] clr_mask;
  logic [15:0] ctl_q;
  logic [15:0] pending;
  logic        group;
  logic        irq;

  always #2.5 clk = ~clk;

  edge_irq_collector uut (
    .clk(clk), .rst_n(rst_n), .data_a(data_a), .reply_in(reply_in),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .clr_we(clr_we),
    .clr_mask(clr_mask), .ctl_q(ctl_q), .pending(pending),
    .group(group), .irq(irq)
  );

  typedef struct {
    logic [15:0] pend;
    logic [15:0] ctl;
    logic        irq;
    logic        grp;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks   = 0;
  int   failures = 0;
  bit   done     = 1'b0;

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pending !== e.pend || ctl_q !== e.ctl || irq !== e.irq || group !== e.grp) begin
        failures++;
        $display("FAIL %s: pend=%h ctl=%h irq=%b grp=%b expected pend=%h ctl=%h irq=%b grp=%b",
                 e.tag, pending, ctl_q, irq, group, e.pend, e.ctl, e.irq, e.grp);
      end
    end
  end

  task automatic expect_st(input logic [15:0] p, input logic [15:0] c,
                           input logic i, input string tag);
    @(posedge clk);
    exp_q.push_back('{p, c, i, (p != 16'h0), tag});
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_clr(input logic [15:0] m);
    clr_mask = m; clr_we = 1'b1;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    data_a = '0; reply_in = '0; ctl_we = 1'b0; ctl_wdata = '0;
    clr_we = 1'b0; clr_mask = '0;
    do_reset();
    expect_st(16'h0000, 16'h0000, 1'b0, "R1 reset state");

    // R2 latency: third rising edge after the level change
    data_a[3] = 1'b1;
    expect_st(16'h0000, 16'h0000, 1'b0, "R2 not yet after edge 1");
    expect_st(16'h0000, 16'h0000, 1'b0, "R2 not yet after edge 2");
    expect_st(16'h0008, 16'h0000, 1'b0, "R2 captured after edge 3, R7 disabled, R8 group");
    data_a[15] = 1'b1;
    settle();
    expect_st(16'h8008, 16'h0000, 1'b0, "R2 data bit 15 in all-data mode");

    wr_ctl(16'h0200);
    expect_st(16'h8008, 16'h0200, 1'b1, "R7 enable raises irq, R10 readback");
    wr_clr(16'h8000);
    expect_st(16'h0008, 16'h0200, 1'b1, "R5 masked clear");
    data_a = '0;
    settle();
    expect_st(16'h0008, 16'h0200, 1'b1, "R4 falling edge ignored");
    wr_clr(16'hFFFF);
    expect_st(16'h0000, 16'h0200, 1'b0, "R5 clear all, R7 irq drops");

    data_a[5] = 1'b1;
    settle();
    expect_st(16'h0020, 16'h0200, 1'b1, "R4 edge on bit 5");
    wr_clr(16'h0020);
    settle();
    expect_st(16'h0000, 16'h0200, 1'b0, "R4 held level does not retrigger");
    data_a[5] = 1'b0;

    wr_ctl(16'hFFFF);
    expect_st(16'h0000, 16'h0201, 1'b0, "R10 reserved bits read zero");
    data_a[14] = 1'b1;
    settle();
    expect_st(16'h0000, 16'h0201, 1'b0, "R3 data 15:12 ignored in split mode");
    reply_in[2] = 1'b1;
    settle();
    expect_st(16'h4000, 16'h0201, 1'b1, "R3 reply 2 maps to bit 14");
    data_a[11] = 1'b1;
    settle();
    expect_st(16'h4800, 16'h0201, 1'b1, "R3 data 11 maps to bit 11");
    data_a = '0; reply_in = '0;
    settle();
    wr_clr(16'hFFFF);
    expect_st(16'h0000, 16'h0201, 1'b0, "R5 clear after split tests");

    data_a[13] = 1'b1;
    settle();
    expect_st(16'h0000, 16'h0201, 1'b0, "R3 data 13 ignored in split mode");
    wr_ctl(16'h0200);
    settle();
    expect_st(16'h0000, 16'h0200, 1'b0, "R9 switch to all-data with line high");
    reply_in[3] = 1'b1;
    settle();
    expect_st(16'h0000, 16'h0200, 1'b0, "R3 reply ignored in all-data mode");
    wr_ctl(16'h0201);
    settle();
    expect_st(16'h0000, 16'h0201, 1'b0, "R9 switch to split with reply high");
    data_a = '0; reply_in = '0;
    settle();

    data_a[4] = 1'b1;
    settle();
    expect_st(16'h0010, 16'h0201, 1'b1, "R6 preset bit 4");
    data_a[4] = 1'b0;
    settle();
    data_a[4] = 1'b1;
    repeat (2) @(negedge clk);
    clr_mask = 16'h0010; clr_we = 1'b1;
    @(negedge clk);
    clr_we = 1'b0;
    expect_st(16'h0010, 16'h0201, 1'b1, "R6 edge in clear cycle keeps bit");
    data_a[4] = 1'b0;
    settle();
    data_a[4] = 1'b1;
    repeat (3) @(negedge clk);
    clr_mask = 16'h0010; clr_we = 1'b1;
    @(negedge clk);
    clr_we = 1'b0;
    expect_st(16'h0000, 16'h0201, 1'b0, "R6 clear one cycle later removes bit");

    wr_ctl(16'h0001);
    data_a = '0;
    reply_in[0] = 1'b1;
    settle();
    expect_st(16'h1000, 16'h0001, 1'b0, "R7 accumulate while disabled, R8 group");
    wr_ctl(16'h0201);
    expect_st(16'h1000, 16'h0201, 1'b1, "R7 later enable raises irq");

    reply_in = '0;
    settle();
    do_reset();
    expect_st(16'h0000, 16'h0000, 1'b0, "R1 reset mid-run clears state");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule